// File: doc/BRIEF.md
# Dimension-Ordered Wormhole Mesh Router

This block is the switching element of one node in a two-dimensional mesh. It has five ports: one toward each compass neighbour and one to the node's own processor. Traffic arrives as packets. Each packet is a head flit, then any number of body flits, then a tail flit. A packet that is only one flit long uses a combined head-and-tail code. Every input holds at most one flit. Every input and output uses a valid/ready handshake.

The head flit carries the destination column and row. The router compares them with its own position, which is fixed by parameters, and resolves the column first. Only when the column already matches does it move along the row. When both match, the packet is delivered to the local port. The head claims its output, and the output then stays bound to that input until the tail has been accepted downstream. When the output is free and ready, each flit passes the node in the cycle after it arrives. When the output is stalled, the flit waits in its one-flit buffer and back-pressure reaches the upstream link. A round-robin arbiter on each output chooses between heads that arrive together.

Top module: `wormRouter`

## Requirements
- R1: A flit's kind is held in bits [1:0]: 00 body, 01 head, 10 tail, 11 single-flit packet (head and tail at once). On a head, bits [4:2] give the destination column X and bits [7:5] the destination row Y. Every other bit passes through the router unchanged.
- R2: Column first. A head whose X is greater than the router's own column leaves on East (port index 3). A head whose X is smaller leaves on West (index 4). This holds whatever Y is.
- R3: When X matches the own column, a larger Y goes North (index 1), a smaller Y goes South (index 2), and an equal Y goes Local (index 0).
- R4: Each input buffers a single flit. Its ready is high when the buffer is empty, or when the buffered flit is leaving in the same cycle.
- R5: Cut-through. A head accepted on a clock edge is presented on a free, ready output in the next cycle, before the rest of its packet has arrived.
- R6: While an output is valid and not ready, its data stays stable and valid stays high. The stalled input then drops ready once its next flit is waiting.
- R7: Once a head has been accepted on an output, that output carries only the flits of the same packet, in order, until the tail has been accepted.
- R8: Heads that compete for one free output are granted in round-robin order. The search starts one index past the previous winner. After reset the search starts at index 0.
- R9: An output becomes free in the cycle its tail or single-flit packet is accepted, and the next packet can claim it afterwards.
- R10: After reset, all inputs are ready and no output is valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inData | input | 5 x FLIT_W | Incoming flit for each port (index 0 Local, 1 North, 2 South, 3 East, 4 West) |
| inValid | input | 5 | Incoming flit is present |
| inReady | output | 5 | Input buffer can take a flit |
| outData | output | 5 x FLIT_W | Outgoing flit for each port |
| outValid | output | 5 | Outgoing flit is present |
| outReady | input | 5 | Downstream can take the flit |

## Verification
A stale or wrong output lock shows up at the ports in one of two ways. Flits from two packets interleave on one output, or a body flit never leaves, so its input's ready stays low. Either shows within a packet length of the fault. A wrong route choice appears on the very first cycle a head is valid, because the flit comes out on the wrong port index. A pointer that advances wrongly changes the order of competing heads. That order is observed when a blocked local port is released.

// File: rtl/routerPkg.sv
package routerPkg;
  localparam int NUM_PORTS  = 5;
  localparam int PORT_IDX_W = 3;

  localparam logic [PORT_IDX_W-1:0] PORT_LOCAL = 3'd0;
  localparam logic [PORT_IDX_W-1:0] PORT_NORTH = 3'd1;
  localparam logic [PORT_IDX_W-1:0] PORT_SOUTH = 3'd2;
  localparam logic [PORT_IDX_W-1:0] PORT_EAST  = 3'd3;
  localparam logic [PORT_IDX_W-1:0] PORT_WEST  = 3'd4;

  typedef enum logic [1:0] {
    KIND_BODY   = 2'b00,
    KIND_HEAD   = 2'b01,
    KIND_TAIL   = 2'b10,
    KIND_SINGLE = 2'b11
  } flitKind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [NUM_PORTS-1:0]                 pop;    // input buffer drains this cycle
    logic [NUM_PORTS-1:0]                 drive;  // output presents a flit
    logic [NUM_PORTS-1:0][PORT_IDX_W-1:0] sel;    // input feeding each output
  } xbarStrb_t;
endpackage

// File: rtl/rrArbiter.sv
module rrArbiter #(
  parameter int N     = 5,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [N-1:0]     req,
  input  logic             advance,
  output logic [IDX_W-1:0] grantIdx,
  output logic             anyGrant
);
  logic [IDX_W-1:0] ptr;

  always_comb begin
    anyGrant = 1'b0;
    grantIdx = '0;
    for (int k = 0; k < N; k++) begin
      int idx;
      idx = (int'(ptr) + k) % N;
      if (!anyGrant && req[idx]) begin
        anyGrant = 1'b1;
        grantIdx = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptr <= '0;
    end else if (advance) begin
      ptr <= (grantIdx == IDX_W'(N - 1)) ? '0 : grantIdx + 1'b1;
    end
  end
endmodule

// File: rtl/routerControl.sv
module routerControl
  import routerPkg::*;
#(
  parameter int FLIT_W  = 16,
  parameter int COORD_W = 3,
  parameter int MY_X    = 2,
  parameter int MY_Y    = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_PORTS-1:0]              bufValid,
  input  logic [NUM_PORTS-1:0][FLIT_W-1:0]  bufFlit,
  input  logic [NUM_PORTS-1:0]              outReady,
  output xbarStrb_t                         strb
);
  localparam int X_LSB = 2;
  localparam int Y_LSB = 2 + COORD_W;
  localparam logic [COORD_W-1:0] SELF_X = COORD_W'(MY_X);
  localparam logic [COORD_W-1:0] SELF_Y = COORD_W'(MY_Y);

  logic [NUM_PORTS-1:0][PORT_IDX_W-1:0] routeOf;
  logic [NUM_PORTS-1:0][NUM_PORTS-1:0]  reqMat;   // [output][input]
  logic [NUM_PORTS-1:0]                 driveVec;
  logic [NUM_PORTS-1:0]                 fireVec;
  logic [NUM_PORTS-1:0][PORT_IDX_W-1:0] selVec;
  logic [NUM_PORTS-1:0]                 popVec;

  // column first, then row
  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      logic [COORD_W-1:0] dstX, dstY;
      dstX = bufFlit[i][X_LSB +: COORD_W];
      dstY = bufFlit[i][Y_LSB +: COORD_W];
      if (dstX > SELF_X)      routeOf[i] = PORT_EAST;
      else if (dstX < SELF_X) routeOf[i] = PORT_WEST;
      else if (dstY > SELF_Y) routeOf[i] = PORT_NORTH;
      else if (dstY < SELF_Y) routeOf[i] = PORT_SOUTH;
      else                    routeOf[i] = PORT_LOCAL;
    end
  end

  always_comb begin
    for (int o = 0; o < NUM_PORTS; o++) begin
      for (int i = 0; i < NUM_PORTS; i++) begin
        reqMat[o][i] = bufValid[i] & bufFlit[i][0] &
                       (routeOf[i] == PORT_IDX_W'(o));
      end
    end
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_out
    logic                  locked;
    logic [PORT_IDX_W-1:0] owner;
    logic [PORT_IDX_W-1:0] grantIdx;
    logic                  anyGrant;
    logic                  claimNow;
    logic [PORT_IDX_W-1:0] curOwner;
    logic                  lastFlit;

    assign claimNow = !locked && anyGrant;

    rrArbiter #(.N(NUM_PORTS), .IDX_W(PORT_IDX_W)) u_arb (
      .clk      (clk),
      .rstN     (rstN),
      .req      (reqMat[o]),
      .advance  (claimNow),
      .grantIdx (grantIdx),
      .anyGrant (anyGrant)
    );

    assign curOwner    = locked ? owner : grantIdx;
    assign driveVec[o] = (locked || anyGrant) && bufValid[curOwner];
    assign fireVec[o]  = driveVec[o] && outReady[o];
    assign selVec[o]   = curOwner;
    assign lastFlit    = bufFlit[curOwner][1];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        locked <= 1'b0;
        owner  <= '0;
      end else if (fireVec[o] && lastFlit) begin
        locked <= 1'b0;
      end else if (claimNow) begin
        locked <= 1'b1;
        owner  <= grantIdx;
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_PORTS; i++) begin
      popVec[i] = 1'b0;
      for (int o = 0; o < NUM_PORTS; o++) begin
        if (fireVec[o] && selVec[o] == PORT_IDX_W'(i)) popVec[i] = 1'b1;
      end
    end
  end

  assign strb = '{pop: popVec, drive: driveVec, sel: selVec};
endmodule

// File: rtl/routerDatapath.sv
module routerDatapath
  import routerPkg::*;
#(
  parameter int FLIT_W = 16
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_PORTS-1:0][FLIT_W-1:0]  inData,
  input  logic [NUM_PORTS-1:0]              inValid,
  output logic [NUM_PORTS-1:0]              inReady,
  input  xbarStrb_t                         strb,
  output logic [NUM_PORTS-1:0]              bufValid,
  output logic [NUM_PORTS-1:0][FLIT_W-1:0]  bufFlit,
  output logic [NUM_PORTS-1:0][FLIT_W-1:0]  outData,
  output logic [NUM_PORTS-1:0]              outValid
);
  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_buf
    assign inReady[i] = !bufValid[i] || strb.pop[i];

    always_ff @(posedge clk) begin
      if (!rstN) begin
        bufValid[i] <= 1'b0;
        bufFlit[i]  <= '0;
      end else if (inValid[i] && inReady[i]) begin
        bufValid[i] <= 1'b1;
        bufFlit[i]  <= inData[i];
      end else if (strb.pop[i]) begin
        bufValid[i] <= 1'b0;
      end
    end
  end

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_mux
    assign outData[o]  = bufFlit[strb.sel[o]];
    assign outValid[o] = strb.drive[o];
  end
endmodule

// File: rtl/wormRouter.sv
module wormRouter
  import routerPkg::*;
#(
  parameter int FLIT_W  = 16,
  parameter int COORD_W = 3,
  parameter int MY_X    = 2,
  parameter int MY_Y    = 2
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  logic [NUM_PORTS-1:0][FLIT_W-1:0]  inData,
  input  logic [NUM_PORTS-1:0]              inValid,
  output logic [NUM_PORTS-1:0]              inReady,
  output logic [NUM_PORTS-1:0][FLIT_W-1:0]  outData,
  output logic [NUM_PORTS-1:0]              outValid,
  input  logic [NUM_PORTS-1:0]              outReady
);
  xbarStrb_t                        strb;
  logic [NUM_PORTS-1:0]             bufValid;
  logic [NUM_PORTS-1:0][FLIT_W-1:0] bufFlit;

  routerControl #(
    .FLIT_W(FLIT_W), .COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .bufValid (bufValid),
    .bufFlit  (bufFlit),
    .outReady (outReady),
    .strb     (strb)
  );

  routerDatapath #(.FLIT_W(FLIT_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .inData   (inData),
    .inValid  (inValid),
    .inReady  (inReady),
    .strb     (strb),
    .bufValid (bufValid),
    .bufFlit  (bufFlit),
    .outData  (outData),
    .outValid (outValid)
  );
endmodule

// File: rtl/wormRouterChecker.sv
module wormRouterChecker
  import routerPkg::*;
#(
  parameter int FLIT_W  = 16,
  parameter int COORD_W = 3,
  parameter int MY_X    = 2,
  parameter int MY_Y    = 2
) (
  input logic                              clk,
  input logic                              rstN,
  input logic [NUM_PORTS-1:0][FLIT_W-1:0]  outData,
  input logic [NUM_PORTS-1:0]              outValid,
  input logic [NUM_PORTS-1:0]              outReady,
  input xbarStrb_t                         strb
);
  function automatic int wantPort(input logic [FLIT_W-1:0] f);
    int dx, dy;
    dx = int'(f[2 +: COORD_W]) - MY_X;
    dy = int'(f[2 + COORD_W +: COORD_W]) - MY_Y;
    if (dx != 0) return (dx > 0) ? 3 : 4;
    if (dy != 0) return (dy > 0) ? 1 : 2;
    return 0;
  endfunction

  for (genvar o = 0; o < NUM_PORTS; o++) begin : g_chk
    // R6
    hold_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid[o] && !outReady[o] |=> outValid[o] && $stable(outData[o]));

    // R2 R3
    route_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid[o] && outData[o][0] |-> wantPort(outData[o]) == o);

    // R7
    lock_chk: assert property (@(posedge clk) disable iff (!rstN)
      outValid[o] && outReady[o] && !outData[o][1] |=> !(outValid[o] && outData[o][0]));
  end

  for (genvar i = 0; i < NUM_PORTS; i++) begin : g_excl
    logic [NUM_PORTS-1:0] users;
    always_comb begin
      for (int o = 0; o < NUM_PORTS; o++)
        users[o] = strb.drive[o] && strb.sel[o] == PORT_IDX_W'(i);
    end
    // R7
    excl_chk: assert property (@(posedge clk) disable iff (!rstN) $onehot0(users));
  end
endmodule

bind wormRouter wormRouterChecker #(
  .FLIT_W(FLIT_W), .COORD_W(COORD_W), .MY_X(MY_X), .MY_Y(MY_Y)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .outData  (outData),
  .outValid (outValid),
  .outReady (outReady),
  .strb     (strb)
);

// File: tb/wormRouter_bench.sv
module wormRouter_bench;
  import routerPkg::*;
  localparam int W  = 16;
  localparam int NP = NUM_PORTS;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [NP-1:0][W-1:0] inData;
  logic [NP-1:0]        inValid;
  logic [NP-1:0]        inReady;
  logic [NP-1:0][W-1:0] outData;
  logic [NP-1:0]        outValid;
  logic [NP-1:0]        outReady = '1;

  logic         tbValid [NP];
  logic [W-1:0] tbData  [NP];

  always #4 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NP; i++) begin
      inValid[i] = tbValid[i];
      inData[i]  = tbData[i];
    end
  end

  wormRouter u_wormRouter (
    .clk(clk), .rstN(rstN), .inData(inData), .inValid(inValid), .inReady(inReady),
    .outData(outData), .outValid(outValid), .outReady(outReady)
  );

  int checks = 0;
  int errs   = 0;
  logic [18:0] expQ [NP][$];
  int  localHeads [$];
  int  curSrc [NP];
  bit  inPkt  [NP];
  int  seqCnt [NP];
  bit  randomReady = 0;
  logic [NP-1:0] blockMask = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [W-1:0] mkFlit(input logic [1:0] kind, input int dx,
                                          input int dy, input int src, input int seq);
    return {5'(seq), 3'(src), 3'(dy), 3'(dx), kind};
  endfunction

  function automatic logic [2:0] expPort(input int dx, input int dy);
    if (dx > 2) return 3'd3;
    if (dx < 2) return 3'd4;
    if (dy > 2) return 3'd1;
    if (dy < 2) return 3'd2;
    return 3'd0;
  endfunction

  task automatic putFlit(input int src, input logic [W-1:0] f);
    @(negedge clk);
    tbValid[src] = 1'b1;
    tbData[src]  = f;
    #1;
    while (!inReady[src]) begin
      @(negedge clk);
      #1;
    end
    @(posedge clk);
    #1 tbValid[src] = 1'b0;
  endtask

  task automatic sendPkt(input int src, input int dx, input int dy, input int len);
    for (int f = 0; f < len; f++) begin
      logic [1:0] kind;
      logic [W-1:0] flit;
      kind = (len == 1) ? KIND_SINGLE : (f == 0) ? KIND_HEAD :
             (f == len - 1) ? KIND_TAIL : KIND_BODY;
      flit = mkFlit(kind, dx, dy, src, seqCnt[src]);
      seqCnt[src]++;
      expQ[src].push_back({expPort(dx, dy), flit});
      putFlit(src, flit);
    end
  endtask

  function automatic int pending();
    int n = 0;
    for (int i = 0; i < NP; i++) n += expQ[i].size();
    return n;
  endfunction

  task automatic waitDrain(input string req);
    for (int n = 0; n < 3000 && pending() != 0; n++) @(negedge clk);
    repeat (2) @(negedge clk);
    check(pending() == 0, req, "flits left undelivered", pending(), 0);
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      inPkt[i] = 0;
      expQ[i].delete();
    end
    localHeads.delete();
    rstN = 1'b1;
  endtask

  // monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      outReady = (randomReady ? lfsr[NP-1:0] | lfsr[12:8] & lfsr[7:3] : '1) & ~blockMask;
      #2;
      if (rstN) begin
        for (int o = 0; o < NP; o++) begin
          if (outValid[o] && outReady[o]) begin
            logic [W-1:0] d;
            int s;
            logic [18:0] e;
            d = outData[o];
            s = int'(d[10:8]);
            if (expQ[s].size() == 0) begin
              check(0, "R1", "unexpected flit", d, 0);
            end else begin
              e = expQ[s].pop_front();
              // R2 R3 port choice, R1 fields unchanged, R5 order
              check(e == {3'(o), d}, "R2 R3 R1", "port and flit", {3'(o), d}, e);
            end
            if (inPkt[o])
              check(s == curSrc[o], "R7", "interleaved source", s, curSrc[o]);
            if (d[0]) begin
              curSrc[o] = s;
              if (o == 0) localHeads.push_back(s);
            end
            inPkt[o] = (d[0] || inPkt[o]) && !d[1];
          end
        end
      end
    end
  end

  task automatic finishRun();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    errs++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    finishRun();
  end

  initial begin
    logic [W-1:0] held;
    for (int i = 0; i < NP; i++) begin
      tbValid[i] = 1'b0;
      tbData[i]  = '0;
      seqCnt[i]  = 0;
      inPkt[i]   = 0;
    end
    doReset();
    @(negedge clk);
    #3;
    // R10 and R4
    check(outValid == '0, "R10", "outValid after reset", outValid, 0);
    check(inReady == '1, "R4", "inReady after reset", inReady, 5'h1f);

    // R5: head appears one cycle after acceptance, before the tail is sent
    fork
      sendPkt(0, 6, 1, 4);
      begin
        @(negedge clk);
        @(negedge clk);
        #3;
        check(outValid[3] == 1'b1, "R5", "head valid on East", outValid[3], 1);
        check(outData[3] == mkFlit(KIND_HEAD, 6, 1, 0, 0), "R5", "head data",
              outData[3], mkFlit(KIND_HEAD, 6, 1, 0, 0));
      end
    join
    waitDrain("R5");

    // R2 R3: one packet to each output, all together
    fork
      sendPkt(1, 0, 5, 3);
      sendPkt(2, 2, 7, 3);
      sendPkt(3, 2, 0, 3);
      sendPkt(4, 2, 2, 3);
      sendPkt(0, 7, 2, 3);
    join
    waitDrain("R2 R3");

    // R6 R7 R9: contention under random back-pressure
    randomReady = 1;
    for (int s = 0; s < NP; s++) begin
      fork
        automatic int src = s;
        for (int k = 0; k < 6; k++)
          sendPkt(src, (src * 3 + k * 5) % 8, (src + k * 3) % 8, 1 + (src + k) % 4);
      join_none
    end
    wait fork;
    waitDrain("R7");
    randomReady = 0;

    // R8 round-robin, R6 stall
    doReset();
    sendPkt(3, 2, 2, 2);
    waitDrain("R8");
    blockMask = 5'b00001;
    fork
      sendPkt(1, 2, 2, 2);
      sendPkt(2, 2, 2, 2);
      sendPkt(4, 2, 2, 2);
    join_none
    repeat (4) @(negedge clk);
    #3;
    check(outValid[0] == 1'b1, "R6", "stalled Local valid", outValid[0], 1);
    check(outData[0][10:8] == 3'd4, "R8", "winner after index 3", outData[0][10:8], 4);
    held = outData[0];
    @(negedge clk);
    #3;
    check(outData[0] == held, "R6", "stalled data stable", outData[0], held);
    check(inReady[4] == 1'b0, "R6", "back-pressure on input 4", inReady[4], 0);
    blockMask = '0;
    wait fork;
    waitDrain("R8");
    check(localHeads.size() == 4, "R8", "local head count", localHeads.size(), 4);
    if (localHeads.size() == 4) begin
      check(localHeads[1] == 4, "R8", "second grant", localHeads[1], 4);
      check(localHeads[2] == 1, "R8", "third grant", localHeads[2], 1);
      check(localHeads[3] == 2, "R8", "fourth grant", localHeads[3], 2);
    end

    // R9: single-flit packet frees the output for the next one
    fork
      sendPkt(1, 5, 4, 1);
      begin
        @(negedge clk);
        sendPkt(2, 6, 0, 3);
      end
      sendPkt(0, 4, 4, 1);
    join
    waitDrain("R9");

    finishRun();
  end
endmodule